// File: doc/BRIEF.md
# Data Space and Mapped Register Page Decoder

This block routes every data-space access of an 8-bit microcontroller core. A 16-bit external data address is sorted into one of four targets: the on-chip XRAM at the top of the space, the on-chip bus-controller register window, an unused gap between the two, or the off-chip bus below them. The XRAM size and whether the register window exists are set by parameters, so one source serves every device variant. Accesses that land in the gap do not reach any target. Reads from the gap return all ones, and writes to it are dropped.

For the 8-bit special function register space, the block keeps a page bit that software writes through a control register. While the bit is clear, every register access goes to the standard page. While it is set, a small list of addresses goes to a second, mapped page, and every other address still goes to the standard page. Hardware never changes the page bit on its own. The block also flags register addresses that support single-bit access. All decode outputs are registered, so they appear one clock after the request.

Top module: `dspace_decode`

## Requirements
- R1: During reset and after it, with no request active, `x_sel`, `x_wr_fwd`, `x_fill`, `s_page` and `s_bitadr` are zero and `map_state` is 0.
- R2: A request to an external address below 16'hF700 sets `x_sel` bit 0 (off-chip bus), and a write is forwarded on `x_wr_fwd`.
- R3: When `HAS_CAN` is 1, addresses 16'hF700 to 16'hF7FF set `x_sel` bit 2 (register window). When `HAS_CAN` is 0, the same addresses are treated as the gap.
- R4: Addresses from 2^16 − `XRAM_BYTES` to 16'hFFFF set `x_sel` bit 1 (XRAM). This range is 16'hFC00 up with 1024 bytes and 16'hFF00 up with 256 bytes.
- R5: Addresses between the window end (or 16'hF700 when there is no window) and the XRAM base set `x_sel` bit 3 (gap). A read there gives `x_fill` = 8'hFF. A write there leaves `x_wr_fwd` at 0. For every other target `x_fill` is 8'h00.
- R6: At most one `x_sel` bit is set, and none is set for a cycle with no request.
- R7: Each decode output reflects the request presented one clock edge earlier.
- R8: A register write (`s_req`, `s_wr`) to control address 8'hB6 loads `s_wbit` into `map_state`. No other access changes it.
- R9: With `map_state` 0, every register request sets `s_page` = 2'b01 (standard page).
- R10: With `map_state` 1, the default mapped addresses 8'h86, 8'h8E, 8'h9E, 8'hBC and 8'hF7 set `s_page` = 2'b10. All other addresses give 2'b01. The page is chosen by the value of `map_state` before the access.
- R11: `s_bitadr` is 1 for a register request whose address has its three low bits equal to zero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_req | input | 1 | External data access request |
| x_addr | input | 16 | External data address |
| x_wr | input | 1 | External access is a write |
| x_sel | output | 4 | One-hot target: 0 off-chip, 1 XRAM, 2 register window, 3 gap |
| x_wr_fwd | output | 1 | Write strobe forwarded to the selected target |
| x_fill | output | 8 | Read data substituted for gap reads |
| s_req | input | 1 | Register space access request |
| s_addr | input | 8 | Register address |
| s_wr | input | 1 | Register access is a write |
| s_wbit | input | 1 | Page bit value written with a control register write |
| s_page | output | 2 | One-hot page: 0 standard, 1 mapped |
| s_bitadr | output | 1 | Address supports single-bit access |
| map_state | output | 1 | Current page bit |

## Verification
All 65536 external addresses are swept in order, alternating reads and writes. The sweep runs on two variants at once: 1 KB XRAM with the register window, and 256 bytes without it. This separates the window from the gap and moves the XRAM base between the two sizes. The alternating direction checks that gap writes are dropped and that the fill value appears only on reads.

The full register address space is swept three times: with the page bit clear, with it set while writes go to every other address, and after it is cleared again. These sweeps separate the mapped list from fall-through addresses and show that the page bit is sticky. The same sweeps cover the single-bit-access flag on every address.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    TGT_EXT  = 2'd0,
    TGT_XRAM = 2'd1,
    TGT_CAN  = 2'd2,
    TGT_HOLE = 2'd3
  } xtgt_e;

  localparam int NUM_XTGT = 4;
  localparam int NUM_PAGE = 2;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/dsd_rstsync.sv
module dsd_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dsd_xdec.sv
module dsd_xdec
  import dsd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int XRAM_BYTES = 1024,
  parameter bit HAS_CAN    = 1'b1,
  parameter int CAN_BASE   = 'hF700,
  parameter int CAN_BYTES  = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output xtgt_e             tgt
);
  localparam int SPACE = 1 << ADDR_W;
  localparam logic [ADDR_W:0] XRAM_LO = (ADDR_W+1)'(SPACE - XRAM_BYTES);
  localparam logic [ADDR_W:0] WIN_LO  = (ADDR_W+1)'(CAN_BASE);
  localparam logic [ADDR_W:0] WIN_HI  = (ADDR_W+1)'(CAN_BASE + CAN_BYTES);

  logic [ADDR_W:0] a_ext;
  logic            xram_hit;
  logic            win_hit;
  logic            ext_hit;

  assign a_ext    = {1'b0, addr};
  assign xram_hit = (a_ext >= XRAM_LO);
  assign ext_hit  = (a_ext < WIN_LO);

  generate
    if (HAS_CAN) begin : g_win
      assign win_hit = (a_ext >= WIN_LO) && (a_ext < WIN_HI);
    end else begin : g_nowin
      assign win_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (xram_hit)     tgt = TGT_XRAM;
    else if (win_hit) tgt = TGT_CAN;
    else if (ext_hit) tgt = TGT_EXT;
    else              tgt = TGT_HOLE;
  end
endmodule

// File: rtl/dsd_sfrdec.sv
module dsd_sfrdec #(
  parameter int SFR_AW  = 8,
  parameter int NUM_MAP = 5,
  parameter logic [NUM_MAP*SFR_AW-1:0] MAP_ADDRS = {8'hF7, 8'hBC, 8'h9E, 8'h8E, 8'h86}
) (
  input  logic [SFR_AW-1:0] addr,
  input  logic              map_on,
  output logic              to_mapped,
  output logic              bit_ok
);
  localparam int BITGRP_W = 3;

  logic [NUM_MAP-1:0] match;

  generate
    for (genvar i = 0; i < NUM_MAP; i++) begin : g_match
      assign match[i] = (addr == MAP_ADDRS[i*SFR_AW +: SFR_AW]);
    end
  endgenerate

  assign to_mapped = map_on && (|match);
  assign bit_ok    = (addr[BITGRP_W-1:0] == '0);
endmodule

// File: rtl/dsd_mapreg.sv
module dsd_mapreg #(
  parameter int SFR_AW = 8,
  parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'hB6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [SFR_AW-1:0] addr,
  input  logic              wbit,
  output logic              map_q
);
  logic map_en;
  logic map_d;

  always_comb begin
    map_en = req && wr && (addr == CTRL_ADDR);
    map_d  = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= 1'b0;
    else if (map_en) map_q <= map_d;
  end
endmodule

// File: rtl/dspace_decode.sv
module dspace_decode
  import dsd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int XRAM_BYTES = 1024,
  parameter bit HAS_CAN    = 1'b1,
  parameter int CAN_BASE   = 'hF700,
  parameter int CAN_BYTES  = 256,
  parameter int SFR_AW     = 8,
  parameter int NUM_MAP    = 5,
  parameter logic [NUM_MAP*SFR_AW-1:0] MAP_ADDRS = {8'hF7, 8'hBC, 8'h9E, 8'h8E, 8'h86},
  parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'hB6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                x_req,
  input  logic [ADDR_W-1:0]   x_addr,
  input  logic                x_wr,
  output logic [NUM_XTGT-1:0] x_sel,
  output logic                x_wr_fwd,
  output logic [7:0]          x_fill,
  input  logic                s_req,
  input  logic [SFR_AW-1:0]   s_addr,
  input  logic                s_wr,
  input  logic                s_wbit,
  output logic [NUM_PAGE-1:0] s_page,
  output logic                s_bitadr,
  output logic                map_state
);
  logic rst_q_n;

  dsd_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  xtgt_e tgt;

  dsd_xdec #(
    .ADDR_W(ADDR_W), .XRAM_BYTES(XRAM_BYTES), .HAS_CAN(HAS_CAN),
    .CAN_BASE(CAN_BASE), .CAN_BYTES(CAN_BYTES)
  ) u_xdec (
    .addr(x_addr), .tgt(tgt)
  );

  logic map_q;
  logic to_mapped;
  logic bit_ok;

  dsd_mapreg #(.SFR_AW(SFR_AW), .CTRL_ADDR(CTRL_ADDR)) u_map (
    .clk(clk), .rst_n(rst_q_n), .req(s_req), .wr(s_wr),
    .addr(s_addr), .wbit(s_wbit), .map_q(map_q)
  );

  dsd_sfrdec #(.SFR_AW(SFR_AW), .NUM_MAP(NUM_MAP), .MAP_ADDRS(MAP_ADDRS)) u_sfr (
    .addr(s_addr), .map_on(map_q), .to_mapped(to_mapped), .bit_ok(bit_ok)
  );

  // next-state decode
  logic [NUM_XTGT-1:0] x_sel_d;
  logic                x_wr_d;
  logic [7:0]          x_fill_d;
  logic [NUM_PAGE-1:0] s_page_d;
  logic                s_bit_d;

  always_comb begin
    x_sel_d  = '0;
    x_wr_d   = 1'b0;
    x_fill_d = 8'h00;
    if (x_req) begin
      x_sel_d[tgt] = 1'b1;
      x_wr_d       = x_wr && (tgt != TGT_HOLE);
      if (!x_wr && (tgt == TGT_HOLE)) x_fill_d = FILL_BYTE;
    end
  end

  always_comb begin
    s_page_d = '0;
    s_bit_d  = 1'b0;
    if (s_req) begin
      s_page_d[to_mapped ? 1 : 0] = 1'b1;
      s_bit_d = bit_ok;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      x_sel    <= '0;
      x_wr_fwd <= 1'b0;
      x_fill   <= 8'h00;
      s_page   <= '0;
      s_bitadr <= 1'b0;
    end else begin
      x_sel    <= x_sel_d;
      x_wr_fwd <= x_wr_d;
      x_fill   <= x_fill_d;
      s_page   <= s_page_d;
      s_bitadr <= s_bit_d;
    end
  end

  assign map_state = map_q;
endmodule

// File: rtl/dsd_chk.sv
module dsd_chk #(
  parameter int ADDR_W     = 16,
  parameter int XRAM_BYTES = 1024,
  parameter int SFR_AW     = 8,
  parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'hB6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              x_req,
  input logic [ADDR_W-1:0] x_addr,
  input logic              x_wr,
  input logic [3:0]        x_sel,
  input logic              x_wr_fwd,
  input logic [7:0]        x_fill,
  input logic              s_req,
  input logic [SFR_AW-1:0] s_addr,
  input logic              s_wr,
  input logic [1:0]        s_page,
  input logic              s_bitadr,
  input logic              map_state
);
  localparam logic [ADDR_W:0] XRAM_LO = (ADDR_W+1)'((1 << ADDR_W) - XRAM_BYTES);

  // R6
  x_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_sel));

  // R7
  x_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sel != 4'b0) |-> $past(x_req));

  // R5
  hole_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_sel[3] |-> (!x_wr_fwd && ($past(x_wr) || x_fill == 8'hFF)));

  // R4
  xram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_sel[1] |-> ({1'b0, $past(x_addr)} >= XRAM_LO));

  // R8
  map_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(s_req && s_wr && (s_addr == CTRL_ADDR)) |-> $stable(map_state));

  // R10
  mapped_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_page[1] |-> ($past(map_state) && $onehot(s_page)));

  // R11
  bitadr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bitadr |-> ($past(s_addr[2:0]) == 3'b000 && $past(s_req)));
endmodule

bind dspace_decode dsd_chk #(
  .ADDR_W(ADDR_W), .XRAM_BYTES(XRAM_BYTES), .SFR_AW(SFR_AW), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .x_req(x_req), .x_addr(x_addr), .x_wr(x_wr),
  .x_sel(x_sel), .x_wr_fwd(x_wr_fwd), .x_fill(x_fill), .s_req(s_req),
  .s_addr(s_addr), .s_wr(s_wr), .s_page(s_page), .s_bitadr(s_bitadr),
  .map_state(map_state)
);

// File: tb/dspace_decode_test.sv
module dspace_decode_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        x_req, x_wr, s_req, s_wr, s_wbit;
  logic [15:0] x_addr;
  logic [7:0]  s_addr;

  logic [3:0] x_sel, x_sel2;
  logic       x_wr_fwd, x_wr_fwd2;
  logic [7:0] x_fill, x_fill2;
  logic [1:0] s_page, s_page2;
  logic       s_bitadr, s_bitadr2, map_state, map_state2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dspace_decode uut (
    .clk(clk), .rst_n(rst_n), .x_req(x_req), .x_addr(x_addr), .x_wr(x_wr),
    .x_sel(x_sel), .x_wr_fwd(x_wr_fwd), .x_fill(x_fill), .s_req(s_req),
    .s_addr(s_addr), .s_wr(s_wr), .s_wbit(s_wbit), .s_page(s_page),
    .s_bitadr(s_bitadr), .map_state(map_state)
  );

  dspace_decode #(.XRAM_BYTES(256), .HAS_CAN(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .x_req(x_req), .x_addr(x_addr), .x_wr(x_wr),
    .x_sel(x_sel2), .x_wr_fwd(x_wr_fwd2), .x_fill(x_fill2), .s_req(s_req),
    .s_addr(s_addr), .s_wr(s_wr), .s_wbit(s_wbit), .s_page(s_page2),
    .s_bitadr(s_bitadr2), .map_state(map_state2)
  );

  function automatic int exp_tgt(int a, int xram, bit win);
    if (a >= 65536 - xram)                    return 1;
    if (win && a >= 'hF700 && a < 'hF800)     return 2;
    if (a < 'hF700)                           return 0;
    return 3;
  endfunction

  function automatic bit is_mapped(int a);
    return (a == 'h86) || (a == 'h8E) || (a == 'h9E) || (a == 'hBC) || (a == 'hF7);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic string tag_of(int t);
    case (t)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic check_x(int t, bit wr, logic [3:0] sel, logic fwd, logic [7:0] fill);
    int es = 1 << t;
    int ew = (wr && t != 3) ? 1 : 0;
    int ef = (!wr && t == 3) ? 'hFF : 0;
    int act = {sel, 3'b0, fwd, fill};
    int expv = (es << 12) | (ew << 8) | ef;
    check(act == expv, tag_of(t), act, expv);
  endtask

  bit map_model;

  task automatic sfr_do(int a, bit wr, bit wb, string req);
    int ep;
    s_req = 1'b1; s_addr = a[7:0]; s_wr = wr; s_wbit = wb;
    ep = (map_model && is_mapped(a)) ? 2 : 1;
    if (wr && a == 'hB6) map_model = wb;
    @(negedge clk);
    check(s_page == ep[1:0], req, s_page, ep);
    check(s_bitadr == (a[2:0] == 0), "R11", s_bitadr, (a[2:0] == 0));
    check(map_state == map_model, "R8", map_state, map_model);
  endtask

  initial begin
    rst_n = 1'b0; x_req = 0; x_wr = 0; x_addr = '0;
    s_req = 0; s_wr = 0; s_wbit = 0; s_addr = '0; map_model = 0;
    repeat (4) @(negedge clk);
    // R1: during reset
    check({x_sel, x_wr_fwd, x_fill, s_page, s_bitadr, map_state} == '0, "R1", x_sel, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({x_sel, x_wr_fwd, x_fill, s_page, s_bitadr, map_state} == '0, "R1", x_sel, 0);
    check({x_sel2, map_state2} == '0, "R1", x_sel2, 0);

    // external sweep, both variants, R7 one-cycle latency throughout
    for (int a = 0; a < 65536; a++) begin
      x_req = 1'b1; x_addr = a[15:0]; x_wr = a[0];
      @(negedge clk);
      check_x(exp_tgt(a, 1024, 1'b1), a[0], x_sel, x_wr_fwd, x_fill);
      check_x(exp_tgt(a, 256, 1'b0), a[0], x_sel2, x_wr_fwd2, x_fill2);
    end
    // R6: no request, no select
    x_req = 1'b0;
    @(negedge clk);
    check(x_sel == 4'b0 && x_sel2 == 4'b0, "R6", x_sel, 0);
    // R7: a single request shows one cycle later then clears
    x_req = 1'b1; x_addr = 16'hFD00; x_wr = 1'b0;
    @(negedge clk);
    x_req = 1'b0;
    check(x_sel == 4'b0010, "R7", x_sel, 2);
    @(negedge clk);
    check(x_sel == 4'b0000, "R7", x_sel, 0);

    // register space, page bit clear
    for (int a = 0; a < 256; a++) sfr_do(a, 1'b0, 1'b1, "R9");
    sfr_do('hB6, 1'b1, 1'b1, "R8");
    // page bit set; writes elsewhere must not clear it
    for (int a = 0; a < 256; a++)
      if (a != 'hB6) sfr_do(a, 1'b1, 1'b0, "R10");
    sfr_do('hB6, 1'b0, 1'b0, "R8");
    sfr_do('hB6, 1'b1, 1'b0, "R8");
    for (int a = 0; a < 256; a++) sfr_do(a, 1'b0, 1'b0, "R9");
    s_req = 1'b0;
    @(negedge clk);
    check(s_page == 2'b00 && s_bitadr == 1'b0, "R1", s_page, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule